// File: doc/BRIEF.md
# Smart Card Socket Power Sequencer

This block orders the power-up and power-down of a single smart card socket. It runs on a free-running system clock. A level enable input asks for the card to be powered, and a supply-good input reports that the card supply regulator has settled. The block drives the supply enable, an enable for each of the three signal paths (reset, I/O and clock), and a force-low control for each of those three pins. A chip with two or more sockets places one instance per socket, and each instance sequences independently of the others.

The card clock arrives asynchronously. It passes through a two-flop synchronizer, and its rising edges are counted to time the opening and closing of the clock path. When the enable is dropped, a system-clock timer measures the clock-stop fallback and the I/O release delay. Both delays are parameters in system-clock cycles, about 9 µs in the target system. A 3-bit phase output exposes the sequencer state so that the order of events can be observed.

Top module: `card_pwr_seq`

## Requirements
- R1: After reset, phase is OFF (0), the supply and all three path enables are low, and all three force-low controls are high. Each force-low control is always the inverse of its path enable.
- R2: When enable is high in OFF, the supply enable rises on the next clock edge with every path still disabled, and phase becomes POWERING (1).
- R3: In POWERING, the reset and I/O paths open on the clock edge that samples supply-good high, and phase becomes IO_OPEN (2). Until then they stay closed.
- R4: In IO_OPEN, the clock path opens when the second synchronized card-clock rising edge since entry is seen, and phase becomes ACTIVE (3). A card-clock rise reaches the state register on the third system edge after it occurs.
- R5: On the edge that samples enable low in IO_OPEN or ACTIVE, the reset path closes with reset forced low, the clock and I/O paths stay as they were, and phase becomes CLK_STOP (4).
- R6: In CLK_STOP, the clock path closes and is forced low when the second card-clock rising edge since entry is seen, and phase becomes IO_STOP (5).
- R7: If the card clock does not toggle, the clock path closes on the edge that is CLK_TO_CYC+1 edges after entry into CLK_STOP.
- R8: The I/O path closes, with phase VCC_STOP (6), on the edge that is IO_TO_CYC+1 edges after entry into CLK_STOP. The supply enable drops one edge later, with phase back to OFF. The supply is never switched off while the I/O path is open.
- R9: If enable drops in POWERING, the sequencer enters CLK_STOP without opening any path, and then completes the full shutdown order to OFF.
- R10: If enable is raised again during shutdown, the shutdown still completes to OFF, and a new power-up starts on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Socket power request (level) |
| vcc_good_i | input | 1 | Card supply has settled |
| card_clk_i | input | 1 | Card clock, asynchronous to clk |
| vcc_en_o | output | 1 | Card supply enable |
| rst_path_en_o | output | 1 | Reset path enable |
| io_path_en_o | output | 1 | I/O path enable |
| clk_path_en_o | output | 1 | Clock path enable |
| rst_force_low_o | output | 1 | Force the reset pin low |
| clk_force_low_o | output | 1 | Force the clock pin low |
| io_force_low_o | output | 1 | Force the I/O pin low |
| phase_o | output | 3 | Sequencer phase (0 to 6) |

## Verification
The hardest case to reach is the close of the clock path during shutdown. There, a card-clock edge and the timer fallback compete to end the same phase. The bench reaches each path on its own. In one run it toggles the card clock just after enable falls, so the edge count closes the clock long before the timer could. In another it holds the card clock still and counts system edges up to the fallback. A third case drops enable before the supply has settled, to show that the aborted sequence never opens a path.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [2:0] {
        PH_OFF      = 3'd0,
        PH_POWERING = 3'd1,
        PH_IO_OPEN  = 3'd2,
        PH_ACTIVE   = 3'd3,
        PH_CLK_STOP = 3'd4,
        PH_IO_STOP  = 3'd5,
        PH_VCC_STOP = 3'd6
    } phase_e;

endpackage

// File: rtl/cps_edge_sync.sv
module cps_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // R4: a rise pulse lasts a single cycle
    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/cps_timer.sv
module cps_timer #(
    parameter int CLK_TO_CYC = 900,
    parameter int IO_TO_CYC  = 900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic clk_hit_o,
    output logic io_hit_o
);
    localparam int MAXT = (CLK_TO_CYC > IO_TO_CYC) ? CLK_TO_CYC : IO_TO_CYC;
    localparam int CW   = $clog2(MAXT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)                   cnt_d = '0;
        else if (cnt_q == CW'(MAXT)) cnt_d = cnt_q;
        else                         cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign clk_hit_o = (cnt_q >= CW'(CLK_TO_CYC));
    assign io_hit_o  = (cnt_q >= CW'(IO_TO_CYC));

    // R7: the counter saturates and never wraps
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAXT));

    // R8: a clear always empties the counter on the next edge
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !io_hit_o || (IO_TO_CYC == 0));

endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
    import cps_pkg::*;
#(
    parameter int OPEN_EDGES  = 2,
    parameter int CLOSE_EDGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       vcc_good_i,
    input  logic       cclk_rise_i,
    input  logic       clk_to_hit_i,
    input  logic       io_to_hit_i,
    output logic       vcc_en_o,
    output logic       rst_path_en_o,
    output logic       io_path_en_o,
    output logic       clk_path_en_o,
    output logic       tmr_clr_o,
    output logic [2:0] phase_o
);
    localparam int MAXE = (OPEN_EDGES > CLOSE_EDGES) ? OPEN_EDGES : CLOSE_EDGES;
    localparam int ECW  = (MAXE < 2) ? 1 : $clog2(MAXE + 1);

    typedef struct packed {
        phase_e         phase;
        logic [ECW-1:0] ecnt;
        logic           vcc;
        logic           rp;
        logic           iop;
        logic           cp;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_OFF: begin
                st_d.vcc = 1'b0;
                st_d.rp  = 1'b0;
                st_d.iop = 1'b0;
                st_d.cp  = 1'b0;
                if (en_i) begin
                    st_d.phase = PH_POWERING;
                    st_d.vcc   = 1'b1;
                end
            end
            PH_POWERING: begin
                if (!en_i) begin
                    st_d.phase = PH_CLK_STOP;
                    st_d.ecnt  = '0;
                end else if (vcc_good_i) begin
                    st_d.phase = PH_IO_OPEN;
                    st_d.rp    = 1'b1;
                    st_d.iop   = 1'b1;
                    st_d.ecnt  = '0;
                end
            end
            PH_IO_OPEN: begin
                if (!en_i) begin
                    st_d.phase = PH_CLK_STOP;
                    st_d.rp    = 1'b0;
                    st_d.ecnt  = '0;
                end else if (cclk_rise_i) begin
                    if (st_q.ecnt == ECW'(OPEN_EDGES - 1)) begin
                        st_d.phase = PH_ACTIVE;
                        st_d.cp    = 1'b1;
                    end else begin
                        st_d.ecnt = st_q.ecnt + 1'b1;
                    end
                end
            end
            PH_ACTIVE: begin
                if (!en_i) begin
                    st_d.phase = PH_CLK_STOP;
                    st_d.rp    = 1'b0;
                    st_d.ecnt  = '0;
                end
            end
            PH_CLK_STOP: begin
                if ((cclk_rise_i && st_q.ecnt == ECW'(CLOSE_EDGES - 1)) || clk_to_hit_i) begin
                    st_d.phase = PH_IO_STOP;
                    st_d.cp    = 1'b0;
                end else if (cclk_rise_i) begin
                    st_d.ecnt = st_q.ecnt + 1'b1;
                end
            end
            PH_IO_STOP: begin
                if (io_to_hit_i) begin
                    st_d.phase = PH_VCC_STOP;
                    st_d.iop   = 1'b0;
                end
            end
            PH_VCC_STOP: begin
                st_d.phase = PH_OFF;
                st_d.vcc   = 1'b0;
            end
            default: begin
                st_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vcc_en_o      = st_q.vcc;
    assign rst_path_en_o = st_q.rp;
    assign io_path_en_o  = st_q.iop;
    assign clk_path_en_o = st_q.cp;
    assign phase_o       = st_q.phase;
    assign tmr_clr_o     = !(st_q.phase inside {PH_CLK_STOP, PH_IO_STOP, PH_VCC_STOP});

    // R2: supply switches on while every path is still closed
    a_r2_supply_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en_o) |-> !rst_path_en_o && !io_path_en_o && !clk_path_en_o);

    // R3: I/O path opens only after supply-good was seen
    a_r3_good_before_io: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_path_en_o) |-> $past(vcc_good_i) && vcc_en_o);

    // R4: clock path opens only after the I/O path
    a_r4_clk_after_io: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_path_en_o) |-> $past(io_path_en_o));

    // R5: falling enable closes the reset path first
    a_r5_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase inside {PH_IO_OPEN, PH_ACTIVE}) && !en_i
        |=> !rst_path_en_o && (io_path_en_o == $past(io_path_en_o)));

    // R6: the clock path is already closed when the I/O path closes
    a_r6_clk_before_io: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_path_en_o) |-> !clk_path_en_o && !rst_path_en_o);

    // R8: supply drops only after the I/O pin was forced low
    a_r8_vcc_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en_o) |-> $past(!io_path_en_o) && !io_path_en_o);

    // R9: abort before the supply settles opens no path
    a_r9_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_POWERING) && !en_i
        |=> !rst_path_en_o && !io_path_en_o && !clk_path_en_o);

endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq #(
    parameter int CLK_TO_CYC  = 900,
    parameter int IO_TO_CYC   = 900,
    parameter int OPEN_EDGES  = 2,
    parameter int CLOSE_EDGES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       vcc_good_i,
    input  logic       card_clk_i,
    output logic       vcc_en_o,
    output logic       rst_path_en_o,
    output logic       io_path_en_o,
    output logic       clk_path_en_o,
    output logic       rst_force_low_o,
    output logic       clk_force_low_o,
    output logic       io_force_low_o,
    output logic [2:0] phase_o
);
    logic cclk_rise;
    logic clk_hit, io_hit, tmr_clr;

    cps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (card_clk_i),
        .rise_o  (cclk_rise)
    );

    cps_timer #(.CLK_TO_CYC(CLK_TO_CYC), .IO_TO_CYC(IO_TO_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .clk_hit_o (clk_hit),
        .io_hit_o  (io_hit)
    );

    cps_fsm #(.OPEN_EDGES(OPEN_EDGES), .CLOSE_EDGES(CLOSE_EDGES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en_i),
        .vcc_good_i    (vcc_good_i),
        .cclk_rise_i   (cclk_rise),
        .clk_to_hit_i  (clk_hit),
        .io_to_hit_i   (io_hit),
        .vcc_en_o      (vcc_en_o),
        .rst_path_en_o (rst_path_en_o),
        .io_path_en_o  (io_path_en_o),
        .clk_path_en_o (clk_path_en_o),
        .tmr_clr_o     (tmr_clr),
        .phase_o       (phase_o)
    );

    assign rst_force_low_o = !rst_path_en_o;
    assign clk_force_low_o = !clk_path_en_o;
    assign io_force_low_o  = !io_path_en_o;

    // R1: an open path is never forced low at the same time
    a_r1_force_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_path_en_o && io_force_low_o) && !(clk_path_en_o && clk_force_low_o));

endmodule

// File: tb/card_pwr_seq_tb_top.sv
module card_pwr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CTO = 40;
    localparam int ITO = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, vg = 1'b0, ck = 1'b0;
    logic vcc, rp, iop, cp, rfl, cfl, iofl;
    logic [2:0] ph;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_pwr_seq #(.CLK_TO_CYC(CTO), .IO_TO_CYC(ITO)) dut_i (
        .clk (clk), .rst_n (rst_n), .en_i (en), .vcc_good_i (vg), .card_clk_i (ck),
        .vcc_en_o (vcc), .rst_path_en_o (rp), .io_path_en_o (iop), .clk_path_en_o (cp),
        .rst_force_low_o (rfl), .clk_force_low_o (cfl), .io_force_low_o (iofl),
        .phase_o (ph)
    );

    // en, vg, ck, edges to wait, expected phase, expected {vcc,rp,iop,cp}, requirement
    typedef struct packed {
        logic       en;
        logic       vg;
        logic       ck;
        logic [7:0] wt;
        logic [2:0] ph;
        logic [3:0] outs;
        logic [3:0] req;
    } step_t;

    localparam step_t STEPS [17] = '{
        '{1'b0,1'b0,1'b0, 8'd2,  3'd0, 4'b0000, 4'd1},  // R1 idle
        '{1'b1,1'b0,1'b0, 8'd1,  3'd1, 4'b1000, 4'd2},  // R2 supply first
        '{1'b1,1'b0,1'b0, 8'd5,  3'd1, 4'b1000, 4'd3},  // R3 waits for good
        '{1'b1,1'b1,1'b0, 8'd1,  3'd2, 4'b1110, 4'd3},  // R3 paths open
        '{1'b1,1'b1,1'b1, 8'd3,  3'd2, 4'b1110, 4'd4},  // R4 first rise
        '{1'b1,1'b1,1'b0, 8'd3,  3'd2, 4'b1110, 4'd4},
        '{1'b1,1'b1,1'b1, 8'd2,  3'd2, 4'b1110, 4'd4},  // R4 second rise in flight
        '{1'b1,1'b1,1'b1, 8'd1,  3'd3, 4'b1111, 4'd4},  // R4 clock open
        '{1'b1,1'b1,1'b0, 8'd3,  3'd3, 4'b1111, 4'd4},
        '{1'b0,1'b1,1'b0, 8'd1,  3'd4, 4'b1011, 4'd5},  // R5 reset closes first
        '{1'b0,1'b1,1'b1, 8'd3,  3'd4, 4'b1011, 4'd6},  // R6 first rise
        '{1'b0,1'b1,1'b0, 8'd3,  3'd4, 4'b1011, 4'd6},
        '{1'b0,1'b1,1'b1, 8'd2,  3'd4, 4'b1011, 4'd6},
        '{1'b0,1'b1,1'b1, 8'd1,  3'd5, 4'b1010, 4'd6},  // R6 clock closed
        '{1'b0,1'b1,1'b0, 8'd51, 3'd5, 4'b1010, 4'd8},  // R8 edge ITO after entry
        '{1'b0,1'b1,1'b0, 8'd1,  3'd6, 4'b1000, 4'd8},  // R8 I/O closed
        '{1'b0,1'b1,1'b0, 8'd1,  3'd0, 4'b0000, 4'd8}   // R8 supply off
    };

    task automatic check(input int req, input logic [2:0] eph, input logic [3:0] eo);
        logic [9:0] act, exp;
        act = {ph, vcc, rp, iop, cp, rfl, cfl, iofl};
        exp = {eph, eo, ~eo[2], ~eo[0], ~eo[1]};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_active();
        en = 1'b1; vg = 1'b1; edges(2);
        ck = 1'b1; edges(3);
        ck = 1'b0; edges(3);
        ck = 1'b1; edges(3);
        ck = 1'b0; edges(3);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, 3'd0, 4'b0000);                 // R1 in reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 3'd0, 4'b0000);                 // R1 after reset

        for (int s = 0; s < 17; s++) begin
            en = STEPS[s].en; vg = STEPS[s].vg; ck = STEPS[s].ck;
            edges(int'(STEPS[s].wt));
            check(int'(STEPS[s].req), STEPS[s].ph, STEPS[s].outs);
        end

        // R7: card clock stopped, fallback timer closes the clock path
        go_active();
        check(4, 3'd3, 4'b1111);
        en = 1'b0; edges(CTO + 1);
        check(7, 3'd4, 4'b1011);                 // R7 still open
        edges(1);
        check(7, 3'd5, 4'b1010);                 // R7 closed by timeout
        edges(ITO - CTO - 1);
        check(8, 3'd5, 4'b1010);
        edges(1);
        check(8, 3'd6, 4'b1000);
        edges(1);
        check(8, 3'd0, 4'b0000);

        // R9: abort while powering
        en = 1'b1; vg = 1'b0; edges(1);
        check(9, 3'd1, 4'b1000);
        en = 1'b0; edges(1);
        check(9, 3'd4, 4'b1000);                 // R9 no path opened
        vg = 1'b1; edges(CTO + 1);
        check(9, 3'd5, 4'b1000);
        edges(ITO - CTO);
        check(9, 3'd6, 4'b1000);
        edges(1);
        check(9, 3'd0, 4'b0000);

        // R10: enable raised again during shutdown
        go_active();
        en = 1'b0; edges(1);
        check(5, 3'd4, 4'b1011);
        en = 1'b1; edges(CTO + 1);
        check(10, 3'd5, 4'b1010);                // R10 shutdown continues
        edges(ITO - CTO);
        check(10, 3'd6, 4'b1000);
        edges(1);
        check(10, 3'd0, 4'b0000);
        edges(1);
        check(10, 3'd1, 4'b1000);                // R10 new power-up

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule